// File: doc/BRIEF.md
# Four-Function Integer ALU with Shared Operand Inversion

This block is a purely combinational 32-bit arithmetic-logic unit. It has two operands, a control bit that inverts the second operand, a raw carry input and a two-bit function select. It returns a 32-bit result and the carry from the top stage of its adder. The second operand first passes through a per-bit inversion selector. The selected value then feeds the AND gates, the OR gates and the ripple adder alike, and a four-way result selector picks one of them.

Subtraction is not decoded inside the block. To get a minus b, the caller raises the inversion bit and drives the carry input high. Because the selected operand is shared, raising the inversion bit during a logic function yields a AND NOT b or a OR NOT b. The block has no clock and no state: both outputs follow the inputs within one evaluation.

Dataflow into this block is not handshaked. Operands and controls are plain levels, so there is no back-pressure to honour. A surrounding pipeline stage that needs valid/ready places its registers around this block.

Top module: `alu32_core`

## Requirements
- R1: With op_sel = 2'b00 the result equals opa AND the selected operand, where the selected operand is opb when invert_b = 0.
- R2: With op_sel = 2'b01 the result equals opa OR the selected operand.
- R3: With op_sel = 2'b10 the result equals opa plus the selected operand plus carry_in, taken modulo 2^32. carry_out is bit 32 of that 33-bit sum.
- R4: When invert_b = 1 the adder adds the bitwise complement of opb instead of opb.
- R5: With invert_b = 1, carry_in = 1 and op_sel = 2'b10, the result equals opa minus opb modulo 2^32, and carry_out is 1 exactly when opa >= opb as unsigned values.
- R6: With invert_b = 1, op_sel = 2'b00 gives opa AND NOT opb, and op_sel = 2'b01 gives opa OR NOT opb.
- R7: op_sel = 2'b11 drives the result to all zeros whatever the operands are.
- R8: carry_out always reports the adder's top carry for the current operands, invert_b and carry_in, whatever op_sel selects.
- R9: opa = 0xA5A5A5A5, opb = 0x5A5A5A5A, invert_b = 0 and op_sel = 2'b00 give a result of zero.
- R10: The block is combinational. An input change shows up on result and carry_out without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, before optional inversion |
| invert_b | input | 1 | 1 selects the complement of opb for every function |
| carry_in | input | 1 | Carry into bit 0 of the adder |
| op_sel | input | 2 | 00 AND, 01 OR, 10 add/subtract, 11 zero |
| result | output | 32 | Selected function output |
| carry_out | output | 1 | Carry out of bit 31 of the adder |

## Verification
The bench goes after carry propagation across the full width, such as all-ones plus one. A broken ripple chain would leave stray ones in the result or lose the carry-out. Subtraction with equal operands and with a smaller minuend checks the unsigned borrow sense of carry_out; an inverted borrow convention would flip it in both cases. Inversion under the logic functions and the unused select code are probed with nonzero operands. A design that bypassed the shared selector for AND/OR, or that let code 11 fall through to another path, would return nonzero data there.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  typedef enum logic [1:0] {
    FN_AND   = 2'b00,
    FN_OR    = 2'b01,
    FN_ARITH = 2'b10,
    FN_NONE  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/alu32_bsel.sv
module alu32_bsel #(
  parameter int W = 32
) (
  input  logic [W-1:0] b_raw,
  input  logic         inv,
  output logic [W-1:0] b_eff
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign b_eff[i] = inv ? ~b_raw[i] : b_raw[i];
    end
  endgenerate

  always_comb begin
    // R4
    r4_bsel_inv_chk: assert ((b_eff ^ b_raw) == {W{inv}})
      else $error("operand selector mismatch");
  end
endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o
);
  assign and_o = x & y;
  assign or_o  = x | y;

  always_comb begin
    // R1
    r1_and_subset_chk: assert ((and_o & ~or_o) == '0)
      else $error("and output not contained in or output");
  end
endmodule

// File: rtl/alu32_ripple.sv
module alu32_ripple #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  always_comb begin
    logic c;
    c = cin;
    for (int i = 0; i < W; i++) begin
      sum[i] = x[i] ^ y[i] ^ c;
      c      = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    cout = c;
  end

  always_comb begin
    // R3
    r3_ripple_sum_chk: assert ({cout, sum} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin}))
      else $error("ripple adder disagrees with arithmetic sum");
  end
endmodule

// File: rtl/alu32_outmux.sv
module alu32_outmux
  import alu32_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] and_i,
  input  logic [W-1:0] or_i,
  input  logic [W-1:0] sum_i,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      FN_AND:   y = and_i;
      FN_OR:    y = or_i;
      FN_ARITH: y = sum_i;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         invert_b,
  input  logic         carry_in,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] result,
  output logic         carry_out
);
  logic [W-1:0] b_sel;
  logic [W-1:0] and_v;
  logic [W-1:0] or_v;
  logic [W-1:0] sum_v;
  alu_fn_e      fn;

  assign fn = alu_fn_e'(op_sel);

  alu32_bsel #(.W(W)) u_bsel (
    .b_raw (opb),
    .inv   (invert_b),
    .b_eff (b_sel)
  );

  alu32_logic #(.W(W)) u_logic (
    .x     (opa),
    .y     (b_sel),
    .and_o (and_v),
    .or_o  (or_v)
  );

  alu32_ripple #(.W(W)) u_add (
    .x    (opa),
    .y    (b_sel),
    .cin  (carry_in),
    .sum  (sum_v),
    .cout (carry_out)
  );

  alu32_outmux #(.W(W)) u_mux (
    .fn    (fn),
    .and_i (and_v),
    .or_i  (or_v),
    .sum_i (sum_v),
    .y     (result)
  );

  always_comb begin
    // R7
    r7_unused_zero_chk: assert (op_sel != 2'b11 || result == '0)
      else $error("unused select produced nonzero result");
    // R5
    r5_borrow_chk: assert (!(invert_b && carry_in) || carry_out == (opa >= opb))
      else $error("subtract carry does not match unsigned compare");
    // R6
    r6_and_inv_chk: assert (op_sel != 2'b00 || !invert_b || (result & opb) == '0)
      else $error("inverted AND overlaps opb");
    // R2
    r2_or_cover_chk: assert (op_sel != 2'b01 || (result & opa) == opa)
      else $error("OR result drops bits of opa");
  end
endmodule

// File: tb/alu32_core_tb_top.sv
`timescale 1ns/1ps
module alu32_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opa = '0, opb = '0;
  logic        invert_b = 1'b0, carry_in = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] result;
  logic        carry_out;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  alu32_core dut_i (
    .opa(opa), .opb(opb), .invert_b(invert_b), .carry_in(carry_in),
    .op_sel(op_sel), .result(result), .carry_out(carry_out)
  );

  function automatic logic [32:0] ref_add(logic [31:0] a, logic [31:0] b, logic inv, logic ci);
    logic [31:0] bb;
    bb = inv ? ~b : b;
    return {1'b0, a} + {1'b0, bb} + {32'd0, ci};
  endfunction

  function automatic logic [31:0] ref_res(logic [31:0] a, logic [31:0] b, logic inv, logic ci, logic [1:0] op);
    logic [31:0] bb;
    logic [32:0] s;
    bb = inv ? ~b : b;
    s  = ref_add(a, b, inv, ci);
    case (op)
      2'b00:   return a & bb;
      2'b01:   return a | bb;
      2'b10:   return s[31:0];
      default: return '0;
    endcase
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic inv, logic ci, logic [1:0] op);
    @(negedge clk);
    opa = a; opb = b; invert_b = inv; carry_in = ci; op_sel = op;
    #1;
  endtask

  task automatic chk_res(string tag, logic [31:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_err++;
      $display("FAIL %s result actual=%h expected=%h", tag, result, exp);
    end
  endtask

  task automatic chk_co(string tag, logic exp);
    n_chk++;
    if (carry_out !== exp) begin
      n_err++;
      $display("FAIL %s carry_out actual=%b expected=%b", tag, carry_out, exp);
    end
  endtask

  task automatic full(string tag);
    logic [32:0] s;
    s = ref_add(opa, opb, invert_b, carry_in);
    chk_res(tag, ref_res(opa, opb, invert_b, carry_in, op_sel));
    chk_co(tag, s[32]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time idle inputs: all zero gives AND result 0, carry 0 (R1, R8)
    drive('0, '0, 0, 0, 2'b00);
    chk_res("R1", 32'h0); chk_co("R8", 1'b0);
    // R9 directed vector
    drive(32'hA5A5A5A5, 32'h5A5A5A5A, 0, 0, 2'b00);
    chk_res("R9", 32'h0);
    drive(32'hA5A5A5A5, 32'h5A5A5A5A, 0, 0, 2'b01);
    chk_res("R2", 32'hFFFFFFFF);
    drive(32'hA5A5A5A5, 32'h5A5A5A5A, 0, 0, 2'b10);
    chk_res("R3", 32'hFFFFFFFF); chk_co("R3", 1'b0);
    // R3 full-width carry ripple
    drive(32'hFFFFFFFF, 32'h0, 0, 1, 2'b10);
    chk_res("R3", 32'h0); chk_co("R3", 1'b1);
    // R4 inverted operand without carry
    drive(32'h10, 32'h0, 1, 0, 2'b10);
    chk_res("R4", 32'h0F); chk_co("R4", 1'b1);
    // R5 subtract equal, smaller minuend, larger minuend
    drive(32'h1234, 32'h1234, 1, 1, 2'b10);
    chk_res("R5", 32'h0); chk_co("R5", 1'b1);
    drive(32'h0, 32'h1, 1, 1, 2'b10);
    chk_res("R5", 32'hFFFFFFFF); chk_co("R5", 1'b0);
    drive(32'h80000000, 32'h7FFFFFFF, 1, 1, 2'b10);
    chk_res("R5", 32'h1); chk_co("R5", 1'b1);
    // R6 inversion under logic functions
    drive(32'hF0F0FFFF, 32'h00FF00FF, 1, 0, 2'b00);
    chk_res("R6", 32'hF000FF00);
    drive(32'h00000000, 32'h00FF00FF, 1, 0, 2'b01);
    chk_res("R6", 32'hFF00FF00);
    // R7 unused select with nonzero data; R8 carry still reported
    drive(32'hFFFFFFFF, 32'h1, 0, 0, 2'b11);
    chk_res("R7", 32'h0); chk_co("R8", 1'b1);
    // R10 change mid-cycle with no clock edge in between
    @(posedge clk); #0.5;
    opa = 32'h5; opb = 32'h3; op_sel = 2'b10; invert_b = 0; carry_in = 0;
    #0.5;
    chk_res("R10", 32'h8); chk_co("R10", 1'b0);
    // constrained random
    void'($urandom(32'hC0FFEE));
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] op;
      logic inv, ci;
      op  = 2'($urandom_range(0, 3));
      inv = 1'($urandom_range(0, 1));
      ci  = (op == 2'b10 && inv) ? 1'($urandom_range(0, 3) != 0) : 1'($urandom_range(0, 1));
      drive($urandom, (k % 7 == 0) ? 32'hFFFFFFFF : $urandom, inv, ci, op);
      case (op)
        2'b00:   full(inv ? "R6" : "R1");
        2'b01:   full(inv ? "R6" : "R2");
        2'b10:   full((inv && ci) ? "R5" : (inv ? "R4" : "R3"));
        default: full("R7");
      endcase
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule